// File: doc/BRIEF.md
# Double-Action Timer Capture/Match Channel

This block is a single timer channel with one input pin and one output pin. It has two independent event paths. Each path has a transition-detect latch and a match latch, a 24-bit match register and a 24-bit capture register. Each path reads one of two 24-bit time-base buses. A transition latch records a chosen edge of the conditioned input, and a match latch records a comparison hit against the selected time base. Either kind of event stores the time base into that path's capture register. The match comparison is either exact equality or a modular greater-or-equal test.

The input pin is synchronised by one flop. It then passes through a noise filter that needs a run of identical samples before it changes level, and the filter can be bypassed. The channel logic and the filter advance on every clock, or on every second clock when half-rate operation is chosen. Match events drive the output pin through a per-path action. Match events also raise a channel flag: on the second match only, or on both matches in double-action mode. A host clears every latch and the flag one by one, so the two transition events can occur and be serviced in either order.

Top module: `tmr_dual_event_chan`

## Requirements
- R1: After reset, pin_out, flag, td, md, cap1 and cap2 are all zero, and both match registers are zero.
- R2: With filt_bypass=0, the filtered level takes the synchronised pin value only after that value has differed from it on FILT_SAMPLES (default 3) consecutive enabled samples. A shorter run leaves it unchanged. With filt_bypass=1, the synchronised pin drives edge detection directly, so a rising pin sets a rising-edge latch on the second clock edge at full rate.
- R3: Transition latch n (td[0] for path 1, td[1] for path 2) sets on an enabled edge of the conditioned input chosen by its edge select: bit 0 selects rising, bit 1 selects falling, 2'b11 selects both and 2'b00 selects none. On that edge the path's selected time base is stored into capture register n. While the latch is set it ignores further edges. The two latches are independent, so td[1] may set before td[0].
- R4: clr bits clear one item each: bit 0 clears td[0], bit 1 clears td[1], bit 2 clears md[0], bit 3 clears md[1] and bit 4 clears flag. Each clear leaves the other items untouched. If a latch or the flag is being set in the same cycle as its clear, it ends up set.
- R5: In equal mode (ge_mode[n]=0), comparator n hits when the selected time base equals match register n. In greater-or-equal mode (ge_mode[n]=1), it hits when (time base − match) mod 2^24 is below 2^23.
- R6: An enabled cycle with match_en[n]=1, md[n]=0 and a comparator hit sets md[n] and stores the selected time base into capture register n. While md[n] is set, the comparator cannot fire again. Once md[n] is cleared and the hit persists, it fires again. A match register written through match_we/match_wdata is used for comparison from the next clock onward.
- R7: On a match, pin_out follows the action of that path: 2'b00 hold, 2'b01 drive high, 2'b10 drive low, 2'b11 toggle. When both paths match in the same cycle, the action of path 2 is applied. pin_out changes only on a match.
- R8: flag sets whenever md[1] is set by a match. With flag_both=1 it also sets when md[0] is set by a match. With flag_both=0, a path-1 match leaves it unchanged.
- R9: With half_rate=1, the filter, the edge detector and both event paths advance only on every second clock. Events take correspondingly longer to appear.
- R10: tb_sel[n]=0 makes path n compare and capture tb_a, and tb_sel[n]=1 makes it use tb_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_rate | input | 1 | 1: channel logic advances every second clock |
| filt_bypass | input | 1 | 1: skip the input noise filter |
| pin_in | input | 1 | Channel input pin |
| tb_a | input | 24 | Time-base bus A |
| tb_b | input | 24 | Time-base bus B |
| tb_sel | input | 2 | Per-path bus select (bit n for path n+1) |
| edge_sel1 | input | 2 | Edge select of transition latch 1 |
| edge_sel2 | input | 2 | Edge select of transition latch 2 |
| match_en | input | 2 | Per-path comparator enable |
| ge_mode | input | 2 | Per-path comparator mode, 1 = greater-or-equal |
| flag_both | input | 1 | 1: flag on both matches |
| act1 | input | 2 | Output action of path 1 match |
| act2 | input | 2 | Output action of path 2 match |
| match_we | input | 2 | Per-path match register write strobe |
| match_wdata | input | 24 | Match register write value |
| clr | input | 5 | Per-item clear strobes |
| pin_out | output | 1 | Channel output pin |
| td | output | 2 | Transition-detect latches |
| md | output | 2 | Match latches |
| flag | output | 1 | Channel flag |
| cap1 | output | 24 | Capture register of path 1 |
| cap2 | output | 24 | Capture register of path 2 |

## Verification
Every cycle, the assertions check that a latch stays set until its own clear bit arrives and that capture register 1 is frozen while both of its latches are set. They also check that pin_out moves only in a cycle where a match latch rises, and that a rising md[1] always brings the flag with it. Other behaviours only show up in the bench's scenarios: the filter's sample count, the unordered setting of td[1] before td[0], the modular wrap of the greater-or-equal test, set-over-clear precedence, bus selection and the stretched timing of half-rate operation. The bench checks them with directed sequences and a reference model that runs alongside random traffic.

// File: rtl/tmr_dual_event_chan.sv
module tmr_dual_event_chan #(
  parameter int TW = 24,
  parameter int FILT_SAMPLES = 3,
  localparam int CW = $clog2(FILT_SAMPLES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_rate,
  input  logic          filt_bypass,
  input  logic          pin_in,
  input  logic [TW-1:0] tb_a,
  input  logic [TW-1:0] tb_b,
  input  logic [1:0]    tb_sel,
  input  logic [1:0]    edge_sel1,
  input  logic [1:0]    edge_sel2,
  input  logic [1:0]    match_en,
  input  logic [1:0]    ge_mode,
  input  logic          flag_both,
  input  logic [1:0]    act1,
  input  logic [1:0]    act2,
  input  logic [1:0]    match_we,
  input  logic [TW-1:0] match_wdata,
  input  logic [4:0]    clr,
  output logic          pin_out,
  output logic [1:0]    td,
  output logic [1:0]    md,
  output logic          flag,
  output logic [TW-1:0] cap1,
  output logic [TW-1:0] cap2
);

  logic          phase, en;
  logic          pin_s, filt, prev, level, rise, fall;
  logic [CW-1:0] cnt;
  logic [TW-1:0] mv [2];
  logic [TW-1:0] cap [2];
  logic [TW-1:0] tsel [2];
  logic [TW-1:0] diff [2];
  logic [1:0]    esel [2];
  logic [1:0]    hit, tfire, mfire;
  logic [1:0]    act;

  assign en    = ~half_rate | phase;
  assign level = filt_bypass ? pin_s : filt;
  assign rise  = en & level & ~prev;
  assign fall  = en & ~level & prev;
  assign esel[0] = edge_sel1;
  assign esel[1] = edge_sel2;

  always_comb begin
    for (int n = 0; n < 2; n++) begin
      tsel[n]  = tb_sel[n] ? tb_b : tb_a;
      diff[n]  = tsel[n] - mv[n];
      hit[n]   = ge_mode[n] ? ~diff[n][TW-1] : (tsel[n] == mv[n]);
      mfire[n] = en & match_en[n] & ~md[n] & hit[n];
      tfire[n] = ~td[n] & ((esel[n][0] & rise) | (esel[n][1] & fall));
    end
  end

  assign act = mfire[1] ? act2 : (mfire[0] ? act1 : 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      pin_s <= 1'b0;
      filt  <= 1'b0;
      cnt   <= '0;
      prev  <= 1'b0;
    end else begin
      phase <= ~phase;
      pin_s <= pin_in;
      if (en) begin
        prev <= level;
        if (pin_s != filt) begin
          if (cnt == CW'(FILT_SAMPLES - 1)) begin
            filt <= pin_s;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      td      <= '0;
      md      <= '0;
      flag    <= 1'b0;
      pin_out <= 1'b0;
      for (int n = 0; n < 2; n++) begin
        mv[n]  <= '0;
        cap[n] <= '0;
      end
    end else begin
      td   <= tfire | (td & ~clr[1:0]);
      md   <= mfire | (md & ~clr[3:2]);
      flag <= mfire[1] | (mfire[0] & flag_both) | (flag & ~clr[4]);
      case (act)
        2'b01:   pin_out <= 1'b1;
        2'b10:   pin_out <= 1'b0;
        2'b11:   pin_out <= ~pin_out;
        default: pin_out <= pin_out;
      endcase
      for (int n = 0; n < 2; n++) begin
        if (mfire[n] | tfire[n]) cap[n] <= tsel[n];
        if (match_we[n]) mv[n] <= match_wdata;
      end
    end
  end

  assign cap1 = cap[0];
  assign cap2 = cap[1];

endmodule

// File: rtl/tmr_dual_event_chan_chk.sv
module tmr_dual_event_chan_chk #(
  parameter int TW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    clr,
  input logic [1:0]    td,
  input logic [1:0]    md,
  input logic          flag,
  input logic          pin_out,
  input logic [TW-1:0] cap1
);

  p_td_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (td[0] && !clr[0]) |=> td[0]);

  p_td2_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (td[1] && !clr[1]) |=> td[1]);

  p_md_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (md[1] && !clr[3]) |=> md[1]);

  p_cap_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (md[0] && td[0]) |=> $stable(cap1));

  p_flag_on_m2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(md[1]) |-> flag);

  p_out_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(md[0]) && !$rose(md[1])) |-> $stable(pin_out));

endmodule

bind tmr_dual_event_chan tmr_dual_event_chan_chk #(.TW(TW)) u_chk (.*);

// File: tb/test_tmr_dual_event_chan.sv
module test_tmr_dual_event_chan;
  logic        clk = 0, rst_n = 0;
  logic        half_rate = 0, filt_bypass = 0, pin_in = 0, flag_both = 0;
  logic [23:0] tb_a = 0, tb_b = 0, match_wdata = 0;
  logic [1:0]  tb_sel = 0, edge_sel1 = 0, edge_sel2 = 0, match_en = 0, ge_mode = 0;
  logic [1:0]  act1 = 0, act2 = 0, match_we = 0;
  logic [4:0]  clr = 0;
  logic        pin_out, flag;
  logic [1:0]  td, md;
  logic [23:0] cap1, cap2;
  int checks = 0, errors = 0;
  bit done = 0;

  tmr_dual_event_chan i_tmr_dual_event_chan (.*);

  always #10 clk = ~clk;

  logic ms, mf, mprev, mph, mout, mflag;
  logic [1:0] mtd, mmd;
  int mcnt;
  logic [23:0] mcap [2];
  logic [23:0] mmv [2];

  function automatic bit cmp_hit(bit ge, logic [23:0] t, logic [23:0] m);
    logic [23:0] d;
    d = t - m;
    return ge ? (d < 24'h800000) : (t == m);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mf = 0; mprev = 0; mph = 0; mout = 0; mflag = 0;
      mtd = 0; mmd = 0; mcnt = 0;
      mcap[0] = 0; mcap[1] = 0; mmv[0] = 0; mmv[1] = 0;
    end else begin : mdl
      logic e, lvl, ri, fa;
      logic [1:0] tf, mfr, es, a;
      logic [23:0] t [2];
      e = !half_rate || mph;
      lvl = filt_bypass ? ms : mf;
      ri = e && lvl && !mprev;
      fa = e && !lvl && mprev;
      for (int n = 0; n < 2; n++) begin
        t[n] = tb_sel[n] ? tb_b : tb_a;
        es = (n == 1) ? edge_sel2 : edge_sel1;
        tf[n] = !mtd[n] && ((es[0] && ri) || (es[1] && fa));
        mfr[n] = e && match_en[n] && !mmd[n] && cmp_hit(ge_mode[n], t[n], mmv[n]);
      end
      if (e) begin
        mprev = lvl;
        if (ms != mf) begin
          mcnt++;
          if (mcnt == 3) begin mf = ms; mcnt = 0; end
        end else mcnt = 0;
      end
      ms = pin_in;
      a = mfr[1] ? act2 : (mfr[0] ? act1 : 2'b00);
      if (a == 2'b01) mout = 1; else if (a == 2'b10) mout = 0; else if (a == 2'b11) mout = !mout;
      mflag = mfr[1] || (mfr[0] && flag_both) || (mflag && !clr[4]);
      for (int n = 0; n < 2; n++) begin
        mtd[n] = tf[n] || (mtd[n] && !clr[n]);
        mmd[n] = mfr[n] || (mmd[n] && !clr[2+n]);
        if (tf[n] || mfr[n]) mcap[n] = t[n];
        if (match_we[n]) mmv[n] = match_wdata;
      end
      mph = !mph;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk(td == mtd, "R3", {ctx, " td"}, td, mtd);
    chk(md == mmd, "R6", {ctx, " md"}, md, mmd);
    chk(cap1 == mcap[0] && cap2 == mcap[1], "R6", {ctx, " cap"}, {cap2[7:0], cap1}, {mcap[1][7:0], mcap[0]});
    chk(pin_out == mout, "R7", {ctx, " pin_out"}, pin_out, mout);
    chk(flag == mflag, "R8", {ctx, " flag"}, flag, mflag);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(logic [4:0] c);
    clr = c; step(1); clr = 0;
  endtask

  task automatic wr_match(int n, logic [23:0] v);
    match_wdata = v; match_we = 2'b01 << n; step(1); match_we = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    step(3);
    chk(td == 0 && md == 0 && flag == 0 && pin_out == 0, "R1", "latches after reset", {td, md, flag, pin_out}, 0);
    chk(cap1 == 0 && cap2 == 0, "R1", "captures after reset", cap1 | cap2, 0);
    rst_n = 1;
    step(4);
    check_all("R1 idle");

    // R2 filter: pin held high, filtered rise seen by td0 after 5 edges
    edge_sel1 = 2'b01;
    pin_in = 1;
    step(4);
    chk(td[0] == 0, "R2", "td0 before filter settles", td[0], 0);
    step(1);
    chk(td[0] == 1, "R2", "td0 after 3 filter samples", td[0], 1);
    pin_in = 0; step(8);
    pulse_clr(5'b00001);
    pin_in = 1; step(2); pin_in = 0; step(6);
    chk(td[0] == 0, "R2", "short glitch rejected", td[0], 0);
    check_all("R2");

    // R2 bypass
    filt_bypass = 1;
    pin_in = 1; step(1);
    chk(td[0] == 0, "R2", "bypass td0 after 1 edge", td[0], 0);
    step(1);
    chk(td[0] == 1, "R2", "bypass td0 after 2 edges", td[0], 1);
    check_all("R2 bypass");

    // R3 unordered: td2 on rise set before td1 on fall
    pin_in = 0; step(3);
    pulse_clr(5'b00011);
    edge_sel1 = 2'b10; edge_sel2 = 2'b01; tb_a = 24'h000ABC;
    pin_in = 1; step(2);
    chk(td == 2'b10, "R3", "td2 before td1", td, 2'b10);
    chk(cap2 == 24'h000ABC, "R3", "cap2 on transition", cap2, 24'h000ABC);
    tb_a = 24'h000DEF;
    pin_in = 0; step(2);
    chk(td == 2'b11, "R3", "td1 after fall", td, 2'b11);
    chk(cap2 == 24'h000ABC, "R3", "cap2 held while td2 set", cap2, 24'h000ABC);
    check_all("R3");

    // R5 greater-or-equal across wrap
    tb_a = 24'd5; act1 = 2'b01; flag_both = 0;
    wr_match(0, 24'hFFFFF0);
    match_en = 2'b01; ge_mode = 2'b01;
    step(1);
    chk(md[0] == 1, "R5", "ge hit across wrap", md[0], 1);
    chk(cap1 == 24'd5, "R6", "cap1 on match", cap1, 5);
    chk(pin_out == 1, "R7", "act1 drive high", pin_out, 1);
    chk(flag == 0, "R8", "no flag on m1 without flag_both", flag, 0);
    match_en = 0;
    pulse_clr(5'b00100);
    wr_match(0, 24'h000010);
    match_en = 2'b01; step(3);
    chk(md[0] == 0, "R5", "ge miss when time base behind", md[0], 0);
    ge_mode = 0;
    wr_match(0, 24'd7);
    tb_a = 24'd8; step(3);
    chk(md[0] == 0, "R5", "equal miss", md[0], 0);
    tb_a = 24'd7; step(1);
    chk(md[0] == 1, "R5", "equal hit", md[0], 1);
    check_all("R5");

    // R4 independent clears, set-over-clear
    act2 = 2'b10; ge_mode = 2'b10;
    wr_match(1, 24'd7);
    match_en = 2'b11; step(1);
    chk(md == 2'b11 && flag == 1, "R8", "m2 sets flag", {md, flag}, 3'b111);
    chk(pin_out == 0, "R7", "act2 drive low", pin_out, 0);
    pulse_clr(5'b00001);
    chk(td == 2'b10 && md == 2'b11 && flag == 1, "R4", "only td1 cleared", {td, md, flag}, 5'b10111);
    pulse_clr(5'b01000);
    chk(md == 2'b01, "R4", "only md2 cleared", md, 2'b01);
    clr = 5'b10000; step(1); clr = 0;
    chk(md[1] == 1 && flag == 1, "R4", "set wins over flag clear", {md[1], flag}, 2'b11);
    match_en = 0;
    pulse_clr(5'b10000);
    chk(flag == 0, "R4", "flag cleared", flag, 0);
    check_all("R4");

    // R10 bus select
    tb_sel = 2'b10; tb_b = 24'h123456;
    pin_in = 0; step(2);
    pulse_clr(5'b00010);
    pin_in = 1; step(2);
    chk(cap2 == 24'h123456, "R10", "cap2 from bus B", cap2, 24'h123456);
    check_all("R10");

    // R9 half rate
    half_rate = 1; edge_sel1 = 2'b01;
    pin_in = 0; step(6);
    pulse_clr(5'b00011);
    pin_in = 1; step(1);
    chk(td[0] == 0, "R9", "half rate td0 early", td[0], 0);
    check_all("R9");
    step(2);
    chk(td[0] == 1, "R9", "half rate td0 within 3 edges", td[0], 1);
    check_all("R9");
    filt_bypass = 0; pin_in = 0; step(14);
    check_all("R9 filter");

    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      step(1);
      check_all("rand");
      tb_a = tb_a + 1;
      tb_b = tb_b + 24'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) pin_in = ~pin_in;
      clr = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'b0;
      match_we = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b0;
      match_wdata = tb_a + 24'($urandom_range(0, 40)) - 24'd10;
      if ($urandom_range(0, 63) == 0) begin
        half_rate = 1'($urandom); filt_bypass = 1'($urandom);
        tb_sel = 2'($urandom); edge_sel1 = 2'($urandom); edge_sel2 = 2'($urandom);
        match_en = 2'($urandom); ge_mode = 2'($urandom); flag_both = 1'($urandom);
        act1 = 2'($urandom); act2 = 2'($urandom);
      end
    end
    step(1);
    check_all("final");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule